// File: doc/BRIEF.md
# Scanline Interrupt Generator

This block sits beside a video timing chain and is advanced once per scanline. It tracks the line index inside the frame and decides on which lines the CPU should receive a horizontal interrupt and when it should receive a vertical one. Software sets an 8-bit reload value that controls how often the horizontal interrupt fires. The line count of the frame and the height of the visible area come from a 50/60 Hz standard select and a tall-picture select.

The horizontal counter only runs while the line index is at or below the visible-line count. When the first blanking line is processed, two status bits come on at once: blanking and vertical-event. The vertical pending flag follows a fixed number of CPU cycle strobes later. Pending flags stay set until the CPU acknowledges the matching level. The request output presents level 6 in preference to level 4. Every strobe is a one-clock enable on a single clock, and reset is synchronous and active high.

Top module: `scanline_irq_gen`

## Requirements
- R1: `line_no` advances by one on each `line_stb` and wraps to 0 after line 261 when `pal_mode`=0, or after line 311 when `pal_mode`=1.
- R2: The visible-line count is 240 only when `pal_mode` and `tall_mode` are both 1. In every other case it is 224.
- R3: A `frame_stb`, or the wrap from the last line, sets `line_no` to 0, reloads the horizontal counter from `hreload`, clears status bits 7 and 3, and cancels any vertical gap still running. `frame_stb` wins over a `line_stb` in the same cycle.
- R4: On each processed line whose index is at most the visible-line count, the horizontal counter decrements. When it is 0, it reloads from `hreload` and sets `hpend` instead, so with reload value N, `hpend` sets on every (N+1)-th such line. Lines past the visible count do not touch the counter.
- R5: `irq_level` shows 4 for a set `hpend` only while `hint_en` is 1. `hpend` itself is set regardless of `hint_en`.
- R6: Processing the line whose index equals the visible-line count sets status bit 3 (blanking) and bit 7 (vertical event), so `status` reads 0x88. All other status bits read 0.
- R7: `vpend` sets on the 128th `cyc_stb` after the blanking line was processed. `irq_level` shows 6 for it only while `vint_en` is 1.
- R8: `ack_valid` with `ack_level`=4 clears `hpend`, and with `ack_level`=6 clears `vpend`. An acknowledge of the other level leaves a flag unchanged. A new event in the same cycle wins over the clear.
- R9: When both requests are enabled and pending, `irq_level` is 6. With no enabled pending request it is 0.
- R10: After reset `line_no`, `status`, `hpend`, `vpend` and `irq_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | Process current line and advance |
| frame_stb | input | 1 | Restart the frame |
| cyc_stb | input | 1 | One CPU cycle elapsed |
| pal_mode | input | 1 | 1 = 312-line frame, 0 = 262-line frame |
| tall_mode | input | 1 | Request 240 visible lines (effective with pal_mode) |
| hreload | input | 8 | Horizontal counter reload value |
| hint_en | input | 1 | Enable level-4 request |
| vint_en | input | 1 | Enable level-6 request |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| line_no | output | 9 | Current line index |
| status | output | 8 | Bit 7 vertical event, bit 3 blanking |
| hpend | output | 1 | Horizontal interrupt pending |
| vpend | output | 1 | Vertical interrupt pending |
| irq_level | output | 3 | Requested level: 0, 4 or 6 |

## Verification
The properties assume that `pal_mode` and `tall_mode` change only while `line_no` is below the line count of the new standard. This keeps the line index in range and keeps the blanking line unique within a frame. They also assume that the strobes are single-clock pulses. The stimulus changes the standard and the tall select only right after a frame start, or on low line numbers. All strobes are driven as one-clock pulses from tasks. The bench never raises `line_stb` and `frame_stb` together except where it tests their priority.

// File: rtl/sig_irq_pkg.sv
package sig_irq_pkg;

    localparam int LINE_W   = 9;
    localparam int LEVEL_W  = 3;
    localparam logic [LEVEL_W-1:0] LVL_NONE = 3'd0;
    localparam logic [LEVEL_W-1:0] LVL_HORZ = 3'd4;
    localparam logic [LEVEL_W-1:0] LVL_VERT = 3'd6;

    typedef struct packed {
        logic tick;       // a line is processed this cycle
        logic restart;    // frame begins again this cycle
        logic in_active;  // processed line index <= visible count
        logic at_edge;    // processed line index == visible count
    } line_evt_t;

    function automatic int pick_total(input logic pal, input int ntsc_n, input int pal_n);
        return pal ? pal_n : ntsc_n;
    endfunction

    function automatic int pick_active(input logic pal, input logic tall,
                                       input int short_n, input int tall_n);
        return (pal && tall) ? tall_n : short_n;
    endfunction

endpackage

// File: rtl/sig_line_track.sv
module sig_line_track
    import sig_irq_pkg::*;
#(
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 312,
    parameter int ACT_SHORT  = 224,
    parameter int ACT_TALL   = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic              frame_stb,
    input  logic              pal_mode,
    input  logic              tall_mode,
    output line_evt_t         evt,
    output logic [LINE_W-1:0] line_no
);
    logic [LINE_W-1:0] last_idx;
    logic [LINE_W-1:0] act_idx;
    logic              at_last;

    always_comb begin
        last_idx = LINE_W'(pick_total(pal_mode, NTSC_LINES, PAL_LINES) - 1);
        act_idx  = LINE_W'(pick_active(pal_mode, tall_mode, ACT_SHORT, ACT_TALL));
        at_last  = (line_no >= last_idx);
        evt.tick      = line_stb && !frame_stb;
        evt.restart   = frame_stb || (line_stb && at_last);
        evt.in_active = (line_no <= act_idx);
        evt.at_edge   = (line_no == act_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_no <= '0;
        end else if (evt.restart) begin
            line_no <= '0;
        end else if (evt.tick) begin
            line_no <= line_no + 1'b1;
        end
    end
endmodule

// File: rtl/sig_hcount.sv
module sig_hcount
    import sig_irq_pkg::*;
#(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  line_evt_t           evt,
    input  logic [RELOAD_W-1:0] reload,
    output logic                hfire
);
    logic [RELOAD_W-1:0] cnt;
    logic                step;

    always_comb begin
        step  = !evt.restart && evt.tick && evt.in_active;
        hfire = step && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (evt.restart) begin
            cnt <= reload;
        end else if (step) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sig_vgap.sv
module sig_vgap
    import sig_irq_pkg::*;
#(
    parameter int GAP_CYCLES = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  logic      cyc_stb,
    output logic      blank_flag,
    output logic      vevent_flag,
    output logic      vfire
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES);
    localparam logic [GAP_W-1:0] GAP_ONE  = GAP_W'(1);

    logic [GAP_W-1:0] remain;
    logic             enter;

    always_comb begin
        enter = !evt.restart && evt.tick && evt.at_edge;
        vfire = !evt.restart && !enter && cyc_stb && (remain == GAP_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_flag  <= 1'b0;
            vevent_flag <= 1'b0;
            remain      <= '0;
        end else if (evt.restart) begin
            blank_flag  <= 1'b0;
            vevent_flag <= 1'b0;
            remain      <= '0;
        end else if (enter) begin
            blank_flag  <= 1'b1;
            vevent_flag <= 1'b1;
            remain      <= GAP_LOAD;
        end else if (cyc_stb && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sig_irq_arb.sv
module sig_irq_arb
    import sig_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hfire,
    input  logic               vfire,
    input  logic               hint_en,
    input  logic               vint_en,
    input  logic               ack_valid,
    input  logic [LEVEL_W-1:0] ack_level,
    output logic               hpend,
    output logic               vpend,
    output logic [LEVEL_W-1:0] irq_level
);
    logic ack_h, ack_v;

    always_comb begin
        ack_h = ack_valid && (ack_level == LVL_HORZ);
        ack_v = ack_valid && (ack_level == LVL_VERT);
        if (vpend && vint_en)      irq_level = LVL_VERT;
        else if (hpend && hint_en) irq_level = LVL_HORZ;
        else                       irq_level = LVL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpend <= 1'b0;
            vpend <= 1'b0;
        end else begin
            if (hfire)      hpend <= 1'b1;
            else if (ack_h) hpend <= 1'b0;
            if (vfire)      vpend <= 1'b1;
            else if (ack_v) vpend <= 1'b0;
        end
    end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
    import sig_irq_pkg::*;
#(
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 312,
    parameter int ACT_SHORT  = 224,
    parameter int ACT_TALL   = 240,
    parameter int RELOAD_W   = 8,
    parameter int GAP_CYCLES = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_stb,
    input  logic                frame_stb,
    input  logic                cyc_stb,
    input  logic                pal_mode,
    input  logic                tall_mode,
    input  logic [RELOAD_W-1:0] hreload,
    input  logic                hint_en,
    input  logic                vint_en,
    input  logic                ack_valid,
    input  logic [2:0]          ack_level,
    output logic [8:0]          line_no,
    output logic [7:0]          status,
    output logic                hpend,
    output logic                vpend,
    output logic [2:0]          irq_level
);
    line_evt_t evt;
    logic      hfire, vfire;
    logic      blank_flag, vevent_flag;

    sig_line_track #(
        .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
        .ACT_SHORT(ACT_SHORT),   .ACT_TALL(ACT_TALL)
    ) u_track (
        .clk(clk), .rst(rst), .line_stb(line_stb), .frame_stb(frame_stb),
        .pal_mode(pal_mode), .tall_mode(tall_mode), .evt(evt), .line_no(line_no)
    );

    sig_hcount #(.RELOAD_W(RELOAD_W)) u_hcnt (
        .clk(clk), .rst(rst), .evt(evt), .reload(hreload), .hfire(hfire)
    );

    sig_vgap #(.GAP_CYCLES(GAP_CYCLES)) u_vgap (
        .clk(clk), .rst(rst), .evt(evt), .cyc_stb(cyc_stb),
        .blank_flag(blank_flag), .vevent_flag(vevent_flag), .vfire(vfire)
    );

    sig_irq_arb u_arb (
        .clk(clk), .rst(rst), .hfire(hfire), .vfire(vfire),
        .hint_en(hint_en), .vint_en(vint_en),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .hpend(hpend), .vpend(vpend), .irq_level(irq_level)
    );

    always_comb status = {vevent_flag, 3'b000, blank_flag, 3'b000};
endmodule

// File: rtl/sig_irq_chk.sv
module sig_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_stb,
    input logic       frame_stb,
    input logic       cyc_stb,
    input logic       pal_mode,
    input logic       hint_en,
    input logic       vint_en,
    input logic       ack_valid,
    input logic [2:0] ack_level,
    input logic [8:0] line_no,
    input logic [7:0] status,
    input logic       hpend,
    input logic       vpend,
    input logic [2:0] irq_level
);
    // R1
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        line_no < (pal_mode ? 9'd312 : 9'd262));

    // R3
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (line_no == 9'd0 && status == 8'h00));

    // R6
    blank_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> ($past(line_stb) && status == 8'h88));

    // R7
    vpend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vpend) |-> ($past(cyc_stb) && status[3]));

    // R8
    hpend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hpend) |-> $past(ack_valid && ack_level == 3'd4));

    // R8
    vpend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vpend) |-> $past(ack_valid && ack_level == 3'd6));

    // R9
    vert_first_chk: assert property (@(posedge clk) disable iff (rst)
        (vpend && vint_en) |-> irq_level == 3'd6);

    // R5
    horz_req_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd4) |-> (hpend && hint_en && !(vpend && vint_en)));
endmodule

bind scanline_irq_gen sig_irq_chk u_sig_irq_chk (
    .clk(clk), .rst(rst), .line_stb(line_stb), .frame_stb(frame_stb),
    .cyc_stb(cyc_stb), .pal_mode(pal_mode), .hint_en(hint_en), .vint_en(vint_en),
    .ack_valid(ack_valid), .ack_level(ack_level), .line_no(line_no),
    .status(status), .hpend(hpend), .vpend(vpend), .irq_level(irq_level)
);

// File: tb/test_scanline_irq_gen.sv
`timescale 1ns/1ps
module test_scanline_irq_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0, frame_stb = 1'b0, cyc_stb = 1'b0;
    logic       pal_mode = 1'b0, tall_mode = 1'b0;
    logic [7:0] hreload = 8'd2;
    logic       hint_en = 1'b1, vint_en = 1'b1;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_level = 3'd0;
    logic [8:0] line_no;
    logic [7:0] status;
    logic       hpend, vpend;
    logic [2:0] irq_level;

    typedef struct {
        string      tag;
        logic [8:0] line;
        logic [7:0] stat;
        logic       hp;
        logic       vp;
        logic [2:0] irq;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    scanline_irq_gen i_scanline_irq_gen (
        .clk(clk), .rst(rst), .line_stb(line_stb), .frame_stb(frame_stb),
        .cyc_stb(cyc_stb), .pal_mode(pal_mode), .tall_mode(tall_mode),
        .hreload(hreload), .hint_en(hint_en), .vint_en(vint_en),
        .ack_valid(ack_valid), .ack_level(ack_level), .line_no(line_no),
        .status(status), .hpend(hpend), .vpend(vpend), .irq_level(irq_level)
    );

    // monitor: compares queued expectations 2 ns after each falling edge
    always begin
        @(negedge clk);
        #2;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (line_no !== e.line || status !== e.stat || hpend !== e.hp ||
                vpend !== e.vp || irq_level !== e.irq) begin
                n_fail++;
                $display("FAIL %s: got line=%0d stat=%h hp=%b vp=%b irq=%0d exp line=%0d stat=%h hp=%b vp=%b irq=%0d",
                         e.tag, line_no, status, hpend, vpend, irq_level,
                         e.line, e.stat, e.hp, e.vp, e.irq);
            end
        end
    end

    task automatic expect_out(input string tag, input int ln, input logic [7:0] st,
                              input logic hp, input logic vp, input int irq);
        exp_t e;
        e.tag = tag; e.line = 9'(ln); e.stat = st; e.hp = hp; e.vp = vp; e.irq = 3'(irq);
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_stb = 1'b1;
            @(negedge clk) line_stb = 1'b0;
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cyc_stb = 1'b1;
            @(negedge clk) cyc_stb = 1'b0;
        end
    endtask

    task automatic new_frame();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic ack(input int lvl);
        @(negedge clk) begin ack_valid = 1'b1; ack_level = 3'(lvl); end
        @(negedge clk) ack_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R10 reset", 0, 8'h00, 0, 0, 0);

        new_frame();
        expect_out("R3 frame start", 0, 8'h00, 0, 0, 0);
        lines(2);
        expect_out("R4 no fire yet", 2, 8'h00, 0, 0, 0);
        lines(1);
        expect_out("R4 R5 fire on third line", 3, 8'h00, 1, 0, 4);
        ack(6);
        expect_out("R8 wrong level ack", 3, 8'h00, 1, 0, 4);
        ack(4);
        expect_out("R8 ack level 4", 3, 8'h00, 0, 0, 0);

        hint_en = 1'b0;
        lines(3);
        expect_out("R5 disabled request", 6, 8'h00, 1, 0, 0);
        ack(4);
        lines(218);
        ack(4);
        expect_out("R6 before edge", 224, 8'h00, 0, 0, 0);
        lines(1);
        expect_out("R4 R6 edge line", 225, 8'h88, 1, 0, 0);
        ack(4);
        cycles(127);
        expect_out("R7 gap not elapsed", 225, 8'h88, 0, 0, 0);
        cycles(1);
        expect_out("R7 gap elapsed", 225, 8'h88, 0, 1, 6);
        lines(36);
        expect_out("R4 no count after edge", 261, 8'h88, 0, 1, 6);
        ack(6);
        expect_out("R8 ack level 6", 261, 8'h88, 0, 0, 0);
        lines(1);
        expect_out("R1 R3 wrap ntsc", 0, 8'h00, 0, 0, 0);

        hint_en = 1'b1;
        lines(3);
        expect_out("R3 reload at wrap", 3, 8'h00, 1, 0, 4);
        lines(222);
        cycles(128);
        expect_out("R9 level 6 first", 225, 8'h88, 1, 1, 6);
        vint_en = 1'b0;
        expect_out("R7 vint disabled", 225, 8'h88, 1, 1, 4);
        ack(4);
        ack(6);
        vint_en = 1'b1;
        expect_out("R9 none pending", 225, 8'h00 | 8'h88, 0, 0, 0);

        new_frame();
        expect_out("R3 frame clears status", 0, 8'h00, 0, 0, 0);
        lines(225);
        ack(4);
        cycles(60);
        new_frame();
        cycles(128);
        expect_out("R3 gap cancelled", 0, 8'h00, 0, 0, 0);

        // frame_stb wins over line_stb
        @(negedge clk) begin frame_stb = 1'b1; line_stb = 1'b1; end
        @(negedge clk) begin frame_stb = 1'b0; line_stb = 1'b0; end
        expect_out("R3 frame priority", 0, 8'h00, 0, 0, 0);

        hint_en = 1'b0;
        pal_mode = 1'b1; tall_mode = 1'b1;
        new_frame();
        lines(225);
        ack(4);
        expect_out("R2 tall not yet blank", 225, 8'h00, 0, 0, 0);
        lines(15);
        ack(4);
        expect_out("R2 tall before edge", 240, 8'h00, 0, 0, 0);
        lines(1);
        ack(4);
        expect_out("R2 tall edge", 241, 8'h88, 0, 0, 0);
        lines(70);
        expect_out("R1 pal last line", 311, 8'h88, 0, 0, 0);
        lines(1);
        expect_out("R1 wrap pal", 0, 8'h00, 0, 0, 0);

        tall_mode = 1'b0;
        new_frame();
        lines(225);
        ack(4);
        expect_out("R2 pal short edge", 225, 8'h88, 0, 0, 0);
        pal_mode = 1'b0; tall_mode = 1'b1;
        new_frame();
        lines(225);
        ack(4);
        expect_out("R2 ntsc tall ignored", 225, 8'h88, 0, 0, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule